// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a processor core may leave its instruction stream to service an interrupt, and carries out the entry. It holds a pending reset request and a vector of pending hardware sources. When the global interrupt enable is high and no skip of the next instruction is outstanding, it takes one request. Reset goes first. Otherwise the lowest-numbered pending source wins.

The block takes the current program counter and stack pointer at the moment of acceptance. It writes the return address to a byte-wide data-memory stack through a plain write port, one byte per clock, starting with the least significant byte. The stack pointer steps down by one after every byte. It then loads the vector address into the program counter, asks for the global enable to be cleared, and drops only the serviced request. Two configuration inputs set the vector pitch (one or two words) and the return-address size (one, two or three bytes).

The controller has three states. In `ST_IDLE` the block waits. The transition *accept* leads to `ST_PUSH`, where one byte is written per cycle. The transition *last byte* leads to `ST_LOAD`, where the new program counter, the enable-clear pulse and the final stack pointer are issued for one cycle. The transition *done* returns to `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `mem_we`, `pc_ld`, `gie_clr`, `sp_ld` and `irq_req` are low and `irq_pending` is all zeros.
- R2: While `skip_pending` is high, no request of either kind is accepted, and requests that arrive in that time are still recorded.
- R3: No request of either kind is accepted while `gie` is low.
- R4: A pending reset request beats any hardware source. It uses vector number 0 and leaves `irq_pending` unchanged. After it is taken, its pending flag is gone.
- R5: Among pending hardware sources, the lowest set bit index i wins and uses vector number i+1.
- R6: `pc_new` equals the vector number times 2 when `cfg_wide_vec` is 1, and the vector number itself when it is 0.
- R7: `cfg_pc_mode` sets how many bytes are pushed: 0 gives one byte, 1 gives two bytes, and 2 or 3 gives three bytes. Byte k of the push carries bits [8k+7:8k] of the program counter captured at acceptance, lowest byte first.
- R8: The first write goes to the stack pointer captured at acceptance, and each later write goes one address lower, modulo 2^16. In the load cycle, `sp_new` equals the captured value minus the byte count, with `sp_ld` high.
- R9: In the load cycle, `pc_ld` and `gie_clr` are high for exactly that one cycle.
- R10: A hardware entry clears only the serviced bit of `irq_pending`. `irq_req` is high exactly when some bit of `irq_pending` is set.
- R11: `busy` rises in the cycle after acceptance and falls after the load cycle. While it is high, no second entry starts, a request that arrives does not change the running sequence, and `mem_we` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| skip_pending | input | 1 | A skip of the next instruction is outstanding |
| gie | input | 1 | Global interrupt enable |
| rst_req | input | 1 | Pulse that raises a reset request |
| irq_set | input | PEND_W | Pulses that set hardware pending bits |
| cfg_wide_vec | input | 1 | 1 selects a two-word vector pitch |
| cfg_pc_mode | input | 2 | Return-address size selector |
| pc_cur | input | PC_W | Current program counter, in words |
| sp_cur | input | SP_W | Current stack pointer |
| busy | output | 1 | An entry sequence is running |
| mem_we | output | 1 | Stack write strobe |
| mem_addr | output | SP_W | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| pc_ld | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | PC_W | Vector address, in words |
| gie_clr | output | 1 | Clear the global enable |
| sp_ld | output | 1 | Load `sp_new` into the stack pointer |
| sp_new | output | SP_W | Stack pointer after the pushes |
| irq_pending | output | PEND_W | Recorded hardware sources |
| irq_req | output | 1 | At least one hardware source is pending |

## Verification
The bench builds the block with its defaults: an 8-source pending vector, a 16-bit stack pointer and a 22-bit program counter. With 8 sources, the bench can place the highest and lowest winning indices, and sets that hold several bits, into the same run. With a 16-bit stack pointer, a three-byte push that starts at address 1 wraps through zero. With a 22-bit program counter, the top byte of a three-byte push carries only six live bits, so every pitch and byte-count mode can be exercised with the top address bits set.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2
    } seq_state_t;

    // index of the final pushed byte for a given size selector
    function automatic logic [1:0] last_byte_idx(input logic [1:0] mode);
        unique case (mode)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/irq_lowest.sv
module irq_lowest #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     set,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [W-1:0]     pend,
    output logic             any
);
    logic [W-1:0] pend_q;
    logic [W-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_en) clr_mask = W'(1) << clr_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_mask) | set;
    end

    assign pend = pend_q;
    assign any  = |pend_q;

    // R10: a clear with no new sets removes exactly one recorded source
    a_r10_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set == '0) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int SP_W   = 16,
    parameter int PEND_W = 8,
    parameter int PC_W   = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              skip_pending,
    input  logic              gie,
    input  logic              rst_req,
    input  logic [PEND_W-1:0] irq_set,
    input  logic              cfg_wide_vec,
    input  logic [1:0]        cfg_pc_mode,
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [SP_W-1:0]   sp_cur,
    output logic              busy,
    output logic              mem_we,
    output logic [SP_W-1:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              pc_ld,
    output logic [PC_W-1:0]   pc_new,
    output logic              gie_clr,
    output logic              sp_ld,
    output logic [SP_W-1:0]   sp_new,
    output logic [PEND_W-1:0] irq_pending,
    output logic              irq_req
);
    localparam int IDX_W = $clog2(PEND_W);
    localparam int VEC_W = IDX_W + 1;

    seq_state_t        state_q, state_d;
    logic [PC_W-1:0]   ret_q;
    logic [SP_W-1:0]   sp_q;
    logic [VEC_W-1:0]  vec_q;
    logic [IDX_W-1:0]  idx_q;
    logic              hw_q;
    logic              wide_q;
    logic [1:0]        last_q;
    logic [1:0]        cnt_q;
    logic              rst_pend_q;

    logic              hw_found;
    logic [IDX_W-1:0]  hw_idx;
    logic              accept;
    logic              in_load;
    logic [PC_W+7:0]   ret_ext;

    irq_pend_bank #(.W(PEND_W), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (irq_set),
        .clr_en  (in_load && hw_q),
        .clr_idx (idx_q),
        .pend    (irq_pending),
        .any     (irq_req)
    );

    irq_lowest #(.W(PEND_W), .IDX_W(IDX_W)) u_pick (
        .req   (irq_pending),
        .found (hw_found),
        .idx   (hw_idx)
    );

    assign in_load = (state_q == ST_LOAD);
    assign accept  = (state_q == ST_IDLE) && !skip_pending && gie
                     && (rst_pend_q || hw_found);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)           state_d = ST_PUSH;
            ST_PUSH: if (cnt_q == last_q)  state_d = ST_LOAD;
            ST_LOAD:                       state_d = ST_IDLE;
            default:                       state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ret_q      <= '0;
            sp_q       <= '0;
            vec_q      <= '0;
            idx_q      <= '0;
            hw_q       <= 1'b0;
            wide_q     <= 1'b0;
            last_q     <= '0;
            cnt_q      <= '0;
            rst_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            rst_pend_q <= (rst_pend_q && !(in_load && !hw_q)) || rst_req;
            if (accept) begin
                ret_q  <= pc_cur;
                sp_q   <= sp_cur;
                wide_q <= cfg_wide_vec;
                last_q <= last_byte_idx(cfg_pc_mode);
                cnt_q  <= '0;
                hw_q   <= !rst_pend_q;
                idx_q  <= hw_idx;
                vec_q  <= rst_pend_q ? '0 : VEC_W'(hw_idx) + VEC_W'(1);
            end else if (state_q == ST_PUSH) begin
                sp_q  <= sp_q - SP_W'(1);
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    assign ret_ext = {8'h00, ret_q};

    // outputs decoded from state
    always_comb begin
        busy      = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp_q;
        mem_wdata = ret_ext[cnt_q*8 +: 8];
        pc_ld     = 1'b0;
        gie_clr   = 1'b0;
        sp_ld     = 1'b0;
        sp_new    = sp_q;
        pc_new    = PC_W'(vec_q) << wide_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH: begin
                busy   = 1'b1;
                mem_we = 1'b1;
            end
            ST_LOAD: begin
                busy    = 1'b1;
                pc_ld   = 1'b1;
                gie_clr = 1'b1;
                sp_ld   = 1'b1;
            end
            default: ;
        endcase
    end

    // R11: the stack is never written outside a sequence
    a_r11_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);
    // R2: an outstanding skip keeps the block idle
    a_r2_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && skip_pending) |=> !busy);
    // R3: enable low keeps the block idle
    a_r3_gie_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !gie) |=> !busy);
    // R8: consecutive writes step one address down
    a_r8_sp_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SP_W'(1)));
    // R9: the load strobe lasts one cycle
    a_r9_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |=> (!pc_ld && !busy));
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        skip_pending = 1'b0;
    logic        gie = 1'b0;
    logic        rst_req = 1'b0;
    logic [7:0]  irq_set = '0;
    logic        cfg_wide_vec = 1'b0;
    logic [1:0]  cfg_pc_mode = '0;
    logic [21:0] pc_cur = '0;
    logic [15:0] sp_cur = '0;
    logic        busy, mem_we, pc_ld, gie_clr, sp_ld, irq_req;
    logic [15:0] mem_addr, sp_new;
    logic [7:0]  mem_wdata, irq_pending;
    logic [21:0] pc_new;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .skip_pending(skip_pending), .gie(gie),
        .rst_req(rst_req), .irq_set(irq_set), .cfg_wide_vec(cfg_wide_vec),
        .cfg_pc_mode(cfg_pc_mode), .pc_cur(pc_cur), .sp_cur(sp_cur),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pc_ld(pc_ld), .pc_new(pc_new), .gie_clr(gie_clr), .sp_ld(sp_ld),
        .sp_new(sp_new), .irq_pending(irq_pending), .irq_req(irq_req)
    );

    typedef struct packed {
        logic [7:0]  set;
        logic        wide;
        logic [1:0]  mode;
        logic [21:0] pc;
        logic [15:0] sp;
        logic [21:0] epc;
        logic [1:0]  n;
        logic [7:0]  epend;
    } row_t;

    localparam row_t ROWS [0:4] = '{
        '{8'h01, 1'b0, 2'd0, 22'h012345, 16'h0800, 22'd1,  2'd1, 8'h00},
        '{8'hA0, 1'b1, 2'd1, 22'h3F1234, 16'h0700, 22'd12, 2'd2, 8'h80},
        '{8'h00, 1'b1, 2'd2, 22'h2A5B6C, 16'h0001, 22'd16, 2'd3, 8'h00},
        '{8'h0C, 1'b0, 2'd3, 22'h10FEDC, 16'h1000, 22'd3,  2'd3, 8'h08},
        '{8'h00, 1'b1, 2'd0, 22'h0000FF, 16'h0000, 22'd8,  2'd1, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // caller has set gie=1 at a negedge so acceptance occurs at the next edge
    task automatic expect_entry(input logic [21:0] pc, input logic [15:0] sp,
                                input int n, input logic [21:0] epc, input bit inject);
        @(negedge clk);
        gie    = 1'b0;
        pc_cur = '0;
        chk("R11 busy after accept", 32'(busy), 1);
        for (int k = 0; k < n; k++) begin
            logic [15:0] a;
            a = sp - 16'(k);
            rst_req = (inject && k == 0);
            chk("R7 write strobe", 32'(mem_we), 1);
            chk("R8 write address", 32'(mem_addr), 32'(a));
            chk("R7 byte order", 32'(mem_wdata), 32'((pc >> (8 * k)) & 22'hFF));
            @(negedge clk);
        end
        rst_req = 1'b0;
        chk("R7 push length", 32'(mem_we), 0);
        chk("R9 pc_ld", 32'(pc_ld), 1);
        chk("R9 gie_clr", 32'(gie_clr), 1);
        chk("R6 pc_new", 32'(pc_new), 32'(epc));
        chk("R8 sp_ld", 32'(sp_ld), 1);
        chk("R8 sp_new", 32'(sp_new), 32'(16'(sp - 16'(n))));
        @(negedge clk);
        chk("R11 busy falls", 32'(busy), 0);
        chk("R9 single pulse", 32'(pc_ld), 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 mem_we", 32'(mem_we), 0);
        chk("R1 pc_ld", 32'(pc_ld), 0);
        chk("R1 gie_clr", 32'(gie_clr), 0);
        chk("R1 sp_ld", 32'(sp_ld), 0);
        chk("R1 irq_req", 32'(irq_req), 0);
        chk("R1 irq_pending", 32'(irq_pending), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R5 winner, R6 pitch, R7 sizes, R8 stack, R10 clearing
        for (int i = 0; i < 5; i++) begin
            irq_set      = ROWS[i].set;
            gie          = 1'b0;
            cfg_wide_vec = ROWS[i].wide;
            cfg_pc_mode  = ROWS[i].mode;
            pc_cur       = ROWS[i].pc;
            sp_cur       = ROWS[i].sp;
            @(negedge clk);
            irq_set = '0;
            gie     = 1'b1;
            expect_entry(ROWS[i].pc, ROWS[i].sp, int'(ROWS[i].n), ROWS[i].epc, 1'b0);
            chk("R10 serviced bit cleared", 32'(irq_pending), 32'(ROWS[i].epend));
            chk("R10 irq_req", 32'(irq_req), 32'(|ROWS[i].epend));
        end

        // R2 skip holds off both kinds of request
        skip_pending = 1'b1; gie = 1'b1; irq_set = 8'h02;
        cfg_wide_vec = 1'b0; cfg_pc_mode = 2'd1; pc_cur = 22'h3ABCDE; sp_cur = 16'h0400;
        @(negedge clk);
        irq_set = '0; rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R2 no entry during skip", 32'(busy), 0);
            @(negedge clk);
        end
        chk("R2 request recorded", 32'(irq_pending), 32'h02);
        skip_pending = 1'b0;
        // R4 reset wins over pending source 1
        expect_entry(22'h3ABCDE, 16'h0400, 2, 22'd0, 1'b0);
        chk("R4 hardware untouched", 32'(irq_pending), 32'h02);
        chk("R10 irq_req held", 32'(irq_req), 1);

        // R3 enable low holds off
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R3 no entry with gie low", 32'(busy), 0);
        end
        pc_cur = 22'h000155; sp_cur = 16'h0200; cfg_wide_vec = 1'b1; cfg_pc_mode = 2'd0;
        gie = 1'b1;
        expect_entry(22'h000155, 16'h0200, 1, 22'd4, 1'b0);
        chk("R4 reset flag gone after taken", 32'(irq_pending), 0);

        // R11 request during a sequence does not disturb it
        irq_set = 8'h40;
        @(negedge clk);
        irq_set = '0; pc_cur = 22'h2F00AA; sp_cur = 16'h0100;
        cfg_wide_vec = 1'b0; cfg_pc_mode = 2'd2; gie = 1'b1;
        expect_entry(22'h2F00AA, 16'h0100, 3, 22'd7, 1'b1);
        chk("R10 cleared after source 6", 32'(irq_pending), 0);
        pc_cur = 22'h001234; sp_cur = 16'h0080; gie = 1'b1;
        expect_entry(22'h001234, 16'h0080, 3, 22'd0, 1'b0);
        // R4 no further reset entry remains
        gie = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 reset consumed", 32'(busy), 0);
        end
        gie = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule